// File: doc/BRIEF.md
# Mixture Score Accumulator

This block is the last arithmetic stage of a Gaussian scoring pipeline. For every state, it receives one distance sum per frame for each mixture component. It turns each sum into `sum * scale + weight`, using the scale and weight constants that come with that component. It adds the result into a running score held for that frame. Frames are interleaved, so one score register is kept per frame. Once the last component of a state has been folded in for a frame, the finished score is written to a small output queue. Only one value per frame reaches that queue, and a host drains it through a plain valid/pop read port.

Inputs arrive in component-major order. All frames of component 0 come first, then all frames of component 1, and so on. The frame and component positions therefore come from internal counters and are not inputs. The stage sees few inputs compared with the upstream distance unit, so most of the time it sits idle. Its score registers and counters only change on a beat that is actually accepted. When the queue could not absorb a whole state's results, the block holds off upstream with `in_ready` before it starts the final component.

Top module: `score_accum`

## Requirements
- R1: Each accepted beat adds the signed value `in_sum * in_scale + in_weight` (two's complement, sign-extended to the score width) into the score of the current frame.
- R2: Beats are taken in component-major order: the frame position advances by one per accepted beat and wraps from NF-1 to 0, and the component position advances at each wrap.
- R3: At component position 0 a frame's score starts over from zero, so no state's result depends on any earlier state.
- R4: Exactly one queue entry is written per frame per state, on the beat of the last component (NC-1). Entries come out in frame order 0 to NF-1, each tagged with its frame index in `out_frame`.
- R5: While `in_valid` is low, scores and positions do not change.
- R6: `in_ready` is low at the first beat of the last component (frame 0, component NC-1) while the queue holds more than DEPTH-NF entries, so the queue never overflows. At any other position `in_ready` is high.
- R7: `out_valid` is high whenever the queue is non-empty, and `out_pop` removes the head entry. After reset the queue is empty and `in_ready` is high.
- R8: `out_pop` while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the beat this cycle |
| in_sum | input | SW | Signed distance sum for current frame/component |
| in_scale | input | KW | Signed per-component scale |
| in_weight | input | WW | Signed per-component weight |
| out_valid | output | 1 | Queue head valid |
| out_frame | output | $clog2(NF) | Frame index of head entry |
| out_score | output | AW | Final score of head entry |
| out_pop | input | 1 | Host removes head entry |

## Verification
The bench runs several complete states, including one where every operand sits at its most negative value. A design that sign-extended wrongly, or that skipped the restart at component 0, would report scores that are wrong or that carry over from the previous state. One state is left undrained, and the next state is pushed up to the first beat of its last component. There `in_ready` must stay low until enough entries are popped; a design that checked space per beat, or never checked it at all, would either stall in the middle of a state or drop results. Idle gaps and pops on an empty queue are inserted between beats. A design that acted on either would shift frame tags or duplicate entries.

// File: rtl/score_accum.sv
module score_accum #(
  parameter int SW    = 16,
  parameter int KW    = 16,
  parameter int WW    = 32,
  parameter int AW    = 40,
  parameter int NF    = 10,
  parameter int NC    = 8,
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [SW-1:0] in_sum,
  input  logic signed [KW-1:0] in_scale,
  input  logic signed [WW-1:0] in_weight,
  output logic                 out_valid,
  output logic [$clog2(NF)-1:0] out_frame,
  output logic [AW-1:0]        out_score,
  input  logic                 out_pop
);
  localparam int FW = $clog2(NF);
  localparam int CW = $clog2(NC);
  localparam int PW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);
  localparam int EW = FW + AW;

  logic [AW-1:0] score [NF];
  logic [FW-1:0] frm;
  logic [CW-1:0] comp;
  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] count;

  logic [AW-1:0] sx, kx, wx, base, nxt;
  logic accept, push, pop, last_frm, last_comp;

  assign sx = {{(AW-SW){in_sum[SW-1]}}, in_sum};
  assign kx = {{(AW-KW){in_scale[KW-1]}}, in_scale};
  assign wx = {{(AW-WW){in_weight[WW-1]}}, in_weight};
  assign base = (comp == '0) ? '0 : score[frm];
  assign nxt  = base + sx * kx + wx;

  assign last_frm  = (frm == FW'(NF-1));
  assign last_comp = (comp == CW'(NC-1));
  assign in_ready  = !(last_comp && frm == '0 && count > NW'(DEPTH-NF));
  assign accept    = in_valid && in_ready;
  assign push      = accept && last_comp;
  assign pop       = out_pop && count != '0;

  assign out_valid = count != '0;
  assign {out_frame, out_score} = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm  <= '0;
      comp <= '0;
      for (int i = 0; i < NF; i++) score[i] <= '0;
    end else if (accept) begin
      score[frm] <= nxt;
      frm <= last_frm ? '0 : frm + 1'b1;
      if (last_frm) comp <= last_comp ? '0 : comp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wp] <= {frm, nxt};
        wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + NW'(push) - NW'(pop);
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < NW'(DEPTH) || pop));
  p_last_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last_comp && frm == '0) |-> (count <= NW'(DEPTH-NF)));
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last_frm) |=> (frm == '0));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(frm) && $stable(comp)));
  p_drain_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pop && count == NW'(1) && !push) |=> !out_valid);
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !push) |=> (count == '0));
endmodule

// File: tb/score_accum_test.sv
module score_accum_test;
  localparam int NF = 10, NC = 8;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_pop = 0;
  logic signed [15:0] in_sum = 0, in_scale = 0;
  logic signed [31:0] in_weight = 0;
  logic in_ready, out_valid;
  logic [3:0] out_frame;
  logic [39:0] out_score;
  int tests = 0, fails = 0, seed = 7, nexp = 0, rdx = 0;
  longint expq [64];
  int     frq  [64];
  longint acc [NF];

  always #10 clk = ~clk;

  score_accum uut (.clk, .rst_n, .in_valid, .in_ready, .in_sum, .in_scale,
    .in_weight, .out_valid, .out_frame, .out_score, .out_pop);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return seed;
  endfunction

  task automatic beat(input logic signed [15:0] s, input logic signed [15:0] k,
                      input logic signed [31:0] w, input int f, input int c);
    @(negedge clk);
    in_valid = 1; in_sum = s; in_scale = k; in_weight = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    acc[f] = (c == 0 ? 0 : acc[f]) + longint'(s) * longint'(k) + longint'(w);
    if (c == NC-1) begin expq[nexp] = acc[f]; frq[nexp] = f; nexp++; end
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_state(input int mode, input int stop_c);
    logic signed [15:0] s, k;
    logic signed [31:0] w;
    for (int c = 0; c < NC; c++) begin
      if (c == stop_c) return;
      k = (mode == 1) ? -16'sd32768 : 16'(rnd());
      w = (mode == 1) ? 32'sh80000000 : 32'(rnd() >>> 4);
      for (int f = 0; f < NF; f++) begin
        s = (mode == 1) ? -16'sd32768 : 16'(rnd());
        beat(s, k, w, f, c);
        if (mode == 2 && f == 4) idle(3);
      end
    end
  endtask

  task automatic pop_one();
    @(negedge clk);
    chk(out_valid, "R7 valid", longint'(out_valid), 1);
    chk(out_score == expq[rdx][39:0], "R1/R3 score", longint'(out_score), expq[rdx] & 40'hFFFFFFFFFF);
    chk(int'(out_frame) == frq[rdx], "R4 frame", longint'(out_frame), frq[rdx]);
    rdx++;
    out_pop = 1;
    @(negedge clk); out_pop = 0;
  endtask

  task automatic drain();
    while (rdx < nexp) pop_one();
    @(negedge clk);
    chk(!out_valid, "R4 one entry per frame", longint'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid, "R7 reset empty", longint'(out_valid), 0);
    chk(in_ready, "R7 reset ready", longint'(in_ready), 1);
    out_pop = 1; @(negedge clk); out_pop = 0; @(negedge clk);
    chk(!out_valid, "R8 empty pop", longint'(out_valid), 0);

    run_state(0, NC); idle(2); drain();
    run_state(1, NC); idle(2); drain();
    run_state(2, NC); idle(2); drain();

    run_state(0, NC); idle(2);
    run_state(0, NC-1);
    @(negedge clk); in_valid = 1;
    repeat (3) @(negedge clk);
    chk(!in_ready, "R6 stall at last component", longint'(in_ready), 0);
    in_valid = 0;
    idle(4);
    chk(!in_ready, "R5 idle keeps position", longint'(in_ready), 0);
    repeat (4) pop_one();
    @(negedge clk);
    chk(in_ready, "R6 resume when space", longint'(in_ready), 1);
    for (int f = 0; f < NF; f++) beat(16'(f * 3 - 7), 16'sd11, 32'(f), f, NC-1);
    idle(2); drain();
    run_state(0, NC); idle(1); drain();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule